// File: doc/BRIEF.md
# Rename Window with Move Elimination

This block is the combinational decision logic of a register-rename stage. Each cycle it takes a window of decoded integer instructions and decides, slot by slot, whether the instruction must go to the scheduler or can be finished during rename. An instruction finishes during rename when it reduces to a move of one operand, a move of zero, or a no-op. Such an instruction only rebinds its destination in the rename map. It never takes a physical register and never reaches an issue queue.

For every slot the block resolves both source operands to physical register names. A source that names the destination of an earlier slot in the same window takes the name from the youngest such slot. Otherwise it uses the value read from the map. The block sets the freelist allocation requests and builds the map write-port requests.

The map storage, the freelist storage and the issue queues lie outside the block. Physical register 0 always holds zero, and a map entry bound to it carries a set zero bit.

Top module: `rn_window`

## Requirements
- R1: An operand counts as zero when any of these holds:
  - decode forces it to zero (`in_a_zero`, `in_b_zero`);
  - for an immediate second operand, the immediate comparator (`in_imm_zero`) fires;
  - for a register operand, the resolved source has its zero status set. Architectural x0 always has zero status. A map read has zero status when its zero bit is set. A source forwarded from an earlier slot has zero status when the forwarded physical name is 0.
- R2: For op code 0 (zero-identity ops such as add and or) and op code 2 (xor), with only the second operand zero, the slot becomes kind 1 (move first operand). With only the first operand zero and a register second operand, it becomes kind 2 (move second operand). With only the first operand zero and an immediate second operand, it stays kind 0 (scheduled).
- R3: For op code 1 (subtract), a zero second operand gives kind 1. A zero first operand with a nonzero second operand gives kind 0.
- R4: For op code 1 or 2, two register operands that resolve to the same physical register give kind 3 (move of zero).
- R5: For op code 3 (and), either operand zero gives kind 3. For op codes 0 to 3, both operands zero also gives kind 3.
- R6: For op codes 0 to 3, a slot with destination x0 is kind 4 (no-op). Op codes 4 to 7 are always kind 0, whatever the destination.
- R7: `fl_alloc` of a slot is high exactly when the slot is valid, of kind 0, and has a destination other than x0.
- R8: A source takes the physical name written by the youngest earlier valid slot whose destination is that architectural register (not x0). Without such a slot it takes the map read data, and source x0 takes physical 0.
- R9: When that youngest earlier producer was eliminated, the consumer receives the producer's own resolved source name, or 0 for a move of zero. The zero status travels with it.
- R10: The write data of a slot is set by its kind:
  - kind 0: the freelist register of that slot;
  - kind 1: the resolved first source;
  - kind 2: the resolved second source;
  - kind 3: physical 0.
- R11: Of several valid slots in one window that write the same destination, only the youngest raises `map_we`. `map_waddr` equals the destination.
- R12: An invalid slot reports kind 4 and raises neither `fl_alloc` nor `map_we`.
- R13: The map read addresses of each slot equal its two architectural source fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | N | Slot holds an instruction |
| in_op | input | N x 3 | Op code: 0 zero-identity, 1 subtract, 2 xor, 3 and, 4-7 other |
| in_rd | input | N x AW | Architectural destination |
| in_rs1 | input | N x AW | Architectural first source |
| in_rs2 | input | N x AW | Architectural second source |
| in_use_imm | input | N | Second operand is an immediate |
| in_imm_zero | input | N | Immediate equals zero |
| in_a_zero | input | N | Decode forces first operand to zero |
| in_b_zero | input | N | Decode forces second operand to zero |
| map_rd1_addr | output | N x AW | Map read address, first source |
| map_rd2_addr | output | N x AW | Map read address, second source |
| map_rd1_preg | input | N x PW | Map read data, first source |
| map_rd2_preg | input | N x PW | Map read data, second source |
| map_rd1_zero | input | N | Zero bit of first read |
| map_rd2_zero | input | N | Zero bit of second read |
| fl_preg | input | N x PW | Free physical register offered to the slot |
| fl_alloc | output | N | Take the offered register |
| out_kind | output | N x 3 | 0 scheduled, 1 move first, 2 move second, 3 move zero, 4 no-op |
| out_src1 | output | N x PW | Resolved first source |
| out_src2 | output | N x PW | Resolved second source |
| map_we | output | N | Map write enable |
| map_waddr | output | N x AW | Map write address |
| map_wdata | output | N x PW | Map write data |

## Verification
The bench builds the block with its defaults: four slots, 5-bit architectural and 6-bit physical names. Four slots give chains of three forwarding hops, so an eliminated producer can feed a consumer that itself gets eliminated. Register numbers are drawn mostly from x0 to x7 and map data is often physical 0. Same-window rewrites of one destination, identical operand pairs and zero forwarding through a chain therefore come up often in random windows, alongside the directed cases.

// File: rtl/rn_pkg.sv
`timescale 1ns/1ps
package rn_pkg;

  localparam int OPW = 3;

  localparam logic [OPW-1:0] OP_ZID = 3'd0;
  localparam logic [OPW-1:0] OP_SUB = 3'd1;
  localparam logic [OPW-1:0] OP_XOR = 3'd2;
  localparam logic [OPW-1:0] OP_AND = 3'd3;

  typedef enum logic [2:0] {
    RK_SCHED = 3'd0,
    RK_MOV_A = 3'd1,
    RK_MOV_B = 3'd2,
    RK_ZERO  = 3'd3,
    RK_NOP   = 3'd4
  } rn_kind_e;

  localparam int KW = $bits(rn_kind_e);

  // Ordered rule list: first match wins.
  function automatic rn_kind_e rn_classify(
    input logic [OPW-1:0] op,
    input logic           rd_nz,
    input logic           a_z,
    input logic           b_z,
    input logic           b_imm,
    input logic           same
  );
    if (op > OP_AND)                          return RK_SCHED;
    if (!rd_nz)                               return RK_NOP;
    if (a_z && b_z)                           return RK_ZERO;
    if (op == OP_AND)                         return (a_z || b_z) ? RK_ZERO : RK_SCHED;
    if ((op == OP_SUB || op == OP_XOR) && same) return RK_ZERO;
    if (op == OP_SUB)                         return b_z ? RK_MOV_A : RK_SCHED;
    if (b_z)                                  return RK_MOV_A;
    if (a_z && !b_imm)                        return RK_MOV_B;
    return RK_SCHED;
  endfunction

endpackage

// File: rtl/rn_alloc_ctl.sv
`timescale 1ns/1ps
module rn_alloc_ctl import rn_pkg::*; #(
  parameter int N  = 4,
  parameter int AW = 5
) (
  input  logic [N-1:0]          valid,
  input  logic [N-1:0][KW-1:0]  kind,
  input  logic [N-1:0][AW-1:0]  rd,
  output logic [N-1:0]          alloc
);

  logic [N-1:0] is_sched;

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign is_sched[g] = (kind[g] == KW'(RK_SCHED));
    assign alloc[g]    = valid[g] && is_sched[g] && (rd[g] != '0);
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (alloc[i]) begin
        AST_ALLOC_ONLY_SCHED: assert (kind[i] == KW'(RK_SCHED) && valid[i])
          else $error("alloc on non-scheduled slot"); // R7
      end
    end
  end

endmodule

// File: rtl/rn_map_write_ctl.sv
`timescale 1ns/1ps
module rn_map_write_ctl #(
  parameter int N  = 4,
  parameter int AW = 5,
  parameter int PW = 6
) (
  input  logic [N-1:0]          wr_req,
  input  logic [N-1:0][AW-1:0]  rd,
  input  logic [N-1:0][PW-1:0]  wd,
  output logic [N-1:0]          we,
  output logic [N-1:0][AW-1:0]  waddr,
  output logic [N-1:0][PW-1:0]  wdata
);

  logic [N-1:0] shadowed;

  always_comb begin
    shadowed = '0;
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        if (wr_req[j] && rd[j] == rd[i]) shadowed[i] = 1'b1;
      end
    end
  end

  assign we    = wr_req & ~shadowed;
  assign waddr = rd;
  assign wdata = wd;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (we[i]) begin
        AST_WE_NOT_X0: assert (waddr[i] != '0)
          else $error("map write to x0"); // R11
      end
      for (int j = i + 1; j < N; j++) begin
        if (we[i] && we[j]) begin
          AST_WE_UNIQUE: assert (waddr[i] != waddr[j])
            else $error("two map writes to one register"); // R11
        end
      end
    end
  end

endmodule

// File: rtl/rn_window.sv
`timescale 1ns/1ps
module rn_window import rn_pkg::*; #(
  parameter int N  = 4,
  parameter int AW = 5,
  parameter int PW = 6
) (
  input  logic [N-1:0]               in_valid,
  input  logic [N-1:0][OPW-1:0]      in_op,
  input  logic [N-1:0][AW-1:0]       in_rd,
  input  logic [N-1:0][AW-1:0]       in_rs1,
  input  logic [N-1:0][AW-1:0]       in_rs2,
  input  logic [N-1:0]               in_use_imm,
  input  logic [N-1:0]               in_imm_zero,
  input  logic [N-1:0]               in_a_zero,
  input  logic [N-1:0]               in_b_zero,
  output logic [N-1:0][AW-1:0]       map_rd1_addr,
  output logic [N-1:0][AW-1:0]       map_rd2_addr,
  input  logic [N-1:0][PW-1:0]       map_rd1_preg,
  input  logic [N-1:0][PW-1:0]       map_rd2_preg,
  input  logic [N-1:0]               map_rd1_zero,
  input  logic [N-1:0]               map_rd2_zero,
  input  logic [N-1:0][PW-1:0]       fl_preg,
  output logic [N-1:0]               fl_alloc,
  output logic [N-1:0][KW-1:0]       out_kind,
  output logic [N-1:0][PW-1:0]       out_src1,
  output logic [N-1:0][PW-1:0]       out_src2,
  output logic [N-1:0]               map_we,
  output logic [N-1:0][AW-1:0]       map_waddr,
  output logic [N-1:0][PW-1:0]       map_wdata
);

  // Named internal events, visible to the assertions.
  logic [N-1:0][PW-1:0] s1_p, s2_p, wd_p;
  logic [N-1:0]         s1_z, s2_z, a_z, b_z, same;
  logic [N-1:0]         fwd1_hit, fwd2_hit, wr_req;
  logic [N-1:0][KW-1:0] kind_v;

  assign map_rd1_addr = in_rs1;
  assign map_rd2_addr = in_rs2;

  // Slot-ordered resolution: slot i only reads results of slots below i.
  always_comb begin
    s1_p = '0; s2_p = '0; wd_p = '0;
    s1_z = '0; s2_z = '0; a_z = '0; b_z = '0; same = '0;
    fwd1_hit = '0; fwd2_hit = '0; wr_req = '0;
    kind_v = '0;
    for (int i = 0; i < N; i++) begin
      rn_kind_e k;
      if (in_rs1[i] == '0) begin
        s1_p[i] = '0; s1_z[i] = 1'b1;
      end else begin
        s1_p[i] = map_rd1_preg[i]; s1_z[i] = map_rd1_zero[i];
      end
      if (in_rs2[i] == '0) begin
        s2_p[i] = '0; s2_z[i] = 1'b1;
      end else begin
        s2_p[i] = map_rd2_preg[i]; s2_z[i] = map_rd2_zero[i];
      end
      // Later j overrides earlier j: youngest producer wins.
      for (int j = 0; j < i; j++) begin
        if (wr_req[j] && in_rd[j] == in_rs1[i]) begin
          s1_p[i] = wd_p[j]; s1_z[i] = (wd_p[j] == '0); fwd1_hit[i] = 1'b1;
        end
        if (wr_req[j] && in_rd[j] == in_rs2[i]) begin
          s2_p[i] = wd_p[j]; s2_z[i] = (wd_p[j] == '0); fwd2_hit[i] = 1'b1;
        end
      end
      a_z[i]  = in_a_zero[i] || s1_z[i];
      b_z[i]  = in_use_imm[i] ? (in_imm_zero[i] || in_b_zero[i])
                              : (in_b_zero[i] || s2_z[i]);
      same[i] = !in_use_imm[i] && (s1_p[i] == s2_p[i]);
      k = in_valid[i] ? rn_classify(in_op[i], in_rd[i] != '0, a_z[i], b_z[i],
                                    in_use_imm[i], same[i])
                      : RK_NOP;
      kind_v[i] = k;
      case (k)
        RK_SCHED: wd_p[i] = fl_preg[i];
        RK_MOV_A: wd_p[i] = s1_p[i];
        RK_MOV_B: wd_p[i] = s2_p[i];
        default:  wd_p[i] = '0;
      endcase
      wr_req[i] = in_valid[i] && (in_rd[i] != '0) && (k != RK_NOP);
    end
  end

  assign out_kind = kind_v;
  assign out_src1 = s1_p;
  assign out_src2 = s2_p;

  rn_alloc_ctl #(.N(N), .AW(AW)) u_alloc (
    .valid (in_valid),
    .kind  (kind_v),
    .rd    (in_rd),
    .alloc (fl_alloc)
  );

  rn_map_write_ctl #(.N(N), .AW(AW), .PW(PW)) u_mapwr (
    .wr_req (wr_req),
    .rd     (in_rd),
    .wd     (wd_p),
    .we     (map_we),
    .waddr  (map_waddr),
    .wdata  (map_wdata)
  );

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (in_valid[i] && in_rs1[i] == '0 && !fwd1_hit[i]) begin
        AST_X0_SOURCE: assert (out_src1[i] == '0)
          else $error("x0 source not physical 0"); // R8
      end
      if (map_we[i] && out_kind[i] == KW'(RK_ZERO)) begin
        AST_ZERO_MOVE_DATA: assert (map_wdata[i] == '0)
          else $error("zero move writes nonzero name"); // R10
      end
      if (!in_valid[i]) begin
        AST_INVALID_QUIET: assert (!fl_alloc[i] && !map_we[i])
          else $error("invalid slot active"); // R12
      end
      if (out_kind[i] != KW'(RK_SCHED)) begin
        AST_ELIM_NO_ALLOC: assert (!fl_alloc[i])
          else $error("eliminated slot allocates"); // R7
      end
    end
  end

endmodule

// File: tb/test_rn_window.sv
`timescale 1ns/1ps
module test_rn_window;
  localparam int N = 4, AW = 5, PW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0]          v, use_imm, imm_z, az_d, bz_d, mz1, mz2, alloc, we;
  logic [N-1:0][2:0]     op, kind;
  logic [N-1:0][AW-1:0]  rd, rs1, rs2, ra1, ra2, waddr;
  logic [N-1:0][PW-1:0]  mp1, mp2, flp, s1, s2, wdata;

  rn_window #(.N(N), .AW(AW), .PW(PW)) i_rn_window (
    .in_valid(v), .in_op(op), .in_rd(rd), .in_rs1(rs1), .in_rs2(rs2),
    .in_use_imm(use_imm), .in_imm_zero(imm_z), .in_a_zero(az_d), .in_b_zero(bz_d),
    .map_rd1_addr(ra1), .map_rd2_addr(ra2), .map_rd1_preg(mp1), .map_rd2_preg(mp2),
    .map_rd1_zero(mz1), .map_rd2_zero(mz2), .fl_preg(flp), .fl_alloc(alloc),
    .out_kind(kind), .out_src1(s1), .out_src2(s2),
    .map_we(we), .map_waddr(waddr), .map_wdata(wdata)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Expected results, rebuilt from the requirement text.
  int e_kind[N], e_s1[N], e_s2[N], e_wd[N];
  bit e_alloc[N], e_we[N];

  function automatic int rule(input int o, input bit rdnz, input bit za, input bit zb,
                              input bit imm, input bit eq);
    bit lin;
    if (o >= 4) return 0;                                 // R6
    if (!rdnz) return 4;                                  // R6
    if (za && zb) return 3;                               // R5
    if (o == 3) return (za || zb) ? 3 : 0;                // R5
    if (o != 0 && eq) return 3;                           // R4 (sub, xor)
    lin = (o == 0 || o == 2);
    if (o == 1) return zb ? 1 : 0;                        // R3
    if (lin && zb) return 1;                              // R2
    if (lin && za && !imm) return 2;                      // R2
    return 0;
  endfunction

  task automatic model();
    for (int i = 0; i < N; i++) begin
      int p1, p2; bit z1, z2, za, zb;
      p1 = (rs1[i] == 0) ? 0 : int'(mp1[i]); z1 = (rs1[i] == 0) ? 1'b1 : mz1[i];
      p2 = (rs2[i] == 0) ? 0 : int'(mp2[i]); z2 = (rs2[i] == 0) ? 1'b1 : mz2[i];
      for (int j = i - 1; j >= 0; j--) begin
        if (v[j] && rd[j] != 0 && rd[j] == rs1[i]) begin p1 = e_wd[j]; z1 = (e_wd[j] == 0); break; end
      end
      for (int j = i - 1; j >= 0; j--) begin
        if (v[j] && rd[j] != 0 && rd[j] == rs2[i]) begin p2 = e_wd[j]; z2 = (e_wd[j] == 0); break; end
      end
      za = az_d[i] | z1;
      zb = use_imm[i] ? (imm_z[i] | bz_d[i]) : (bz_d[i] | z2);
      e_s1[i] = p1; e_s2[i] = p2;
      e_kind[i] = v[i] ? rule(int'(op[i]), rd[i] != 0, za, zb, use_imm[i],
                              !use_imm[i] && p1 == p2) : 4;
      e_wd[i] = (e_kind[i] == 0) ? int'(flp[i]) : (e_kind[i] == 1) ? p1 :
                (e_kind[i] == 2) ? p2 : 0;
      e_alloc[i] = v[i] && e_kind[i] == 0 && rd[i] != 0;
    end
    for (int i = 0; i < N; i++) begin
      e_we[i] = v[i] && rd[i] != 0 && e_kind[i] != 4;
      for (int j = i + 1; j < N; j++)
        if (v[j] && rd[j] != 0 && rd[j] == rd[i]) e_we[i] = 0;
    end
  endtask

  task automatic clear();
    v = '0; op = '0; rd = '0; rs1 = '0; rs2 = '0; use_imm = '0; imm_z = '0;
    az_d = '0; bz_d = '0; mp1 = '0; mp2 = '0; mz1 = '0; mz2 = '0;
    for (int i = 0; i < N; i++) flp[i] = PW'(40 + i);
  endtask

  task automatic settle();
    @(posedge clk); #1;
    model();
    @(negedge clk);
  endtask

  task automatic chk_all(input string tag);
    for (int i = 0; i < N; i++) begin
      chk({tag, " kind R1/R2/R3/R4/R5/R6"}, int'(kind[i]), e_kind[i]);
      chk({tag, " alloc R7"}, int'(alloc[i]), int'(e_alloc[i]));
      chk({tag, " we R11"}, int'(we[i]), int'(e_we[i]));
      chk({tag, " raddr R13"}, int'(ra1[i]) * 64 + int'(ra2[i]), int'(rs1[i]) * 64 + int'(rs2[i]));
      if (v[i]) begin
        chk({tag, " src1 R8/R9"}, int'(s1[i]), e_s1[i]);
        chk({tag, " src2 R8/R9"}, int'(s2[i]), e_s2[i]);
      end
      if (e_we[i]) begin
        chk({tag, " wdata R10"}, int'(wdata[i]), e_wd[i]);
        chk({tag, " waddr R11"}, int'(waddr[i]), int'(rd[i]));
      end
    end
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 12345;
    void'($urandom(seed));
    clear();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R12: empty window is quiet.
    settle();
    chk("R12 alloc idle", int'(alloc), 0);
    chk("R12 we idle", int'(we), 0);
    chk("R12 kind idle", int'(kind[0]), 4);

    // R2: add rd=3, rs1=5 (map 9), rs2=x0 -> move first.
    clear(); v[0] = 1; rd[0] = 3; rs1[0] = 5; mp1[0] = 9; settle();
    chk("R2 move first kind", int'(kind[0]), 1);
    chk("R10 move first data", int'(wdata[0]), 9);
    // R2: add rs1=x0 with nonzero immediate -> scheduled.
    clear(); v[0] = 1; rd[0] = 3; use_imm[0] = 1; settle();
    chk("R2 imm move scheduled", int'(kind[0]), 0);
    chk("R7 imm move allocates", int'(alloc[0]), 1);
    chk("R10 scheduled data", int'(wdata[0]), 40);
    // R3: sub with zero first operand only -> scheduled.
    clear(); v[0] = 1; op[0] = 1; rd[0] = 2; rs1[0] = 4; rs2[0] = 6; mz1[0] = 1; mp2[0] = 7; settle();
    chk("R3 sub zero first", int'(kind[0]), 0);
    // R4: xor same register -> zero move.
    clear(); v[0] = 1; op[0] = 2; rd[0] = 2; rs1[0] = 5; rs2[0] = 5; mp1[0] = 12; mp2[0] = 12; settle();
    chk("R4 xor same", int'(kind[0]), 3);
    chk("R10 zero data", int'(wdata[0]), 0);
    // R5: and with decode-forced zero.
    clear(); v[0] = 1; op[0] = 3; rd[0] = 2; rs1[0] = 5; rs2[0] = 6; mp1[0] = 3; mp2[0] = 4; az_d[0] = 1; settle();
    chk("R5 and zero", int'(kind[0]), 3);
    // R1: immediate comparator zero -> move first.
    clear(); v[0] = 1; rd[0] = 2; rs1[0] = 3; mp1[0] = 21; use_imm[0] = 1; imm_z[0] = 1; settle();
    chk("R1 imm zero", int'(kind[0]), 1);
    // R6: destination x0 -> no-op, no alloc, no write.
    clear(); v[0] = 1; rd[0] = 0; rs1[0] = 3; rs2[0] = 4; mp1[0] = 5; mp2[0] = 6; settle();
    chk("R6 rd x0 kind", int'(kind[0]), 4);
    chk("R6 rd x0 we", int'(we[0]), 0);
    // R6/R7: other op with rd x0 scheduled but no alloc.
    clear(); v[0] = 1; op[0] = 5; settle();
    chk("R6 other op kind", int'(kind[0]), 0);
    chk("R7 other op rd x0 alloc", int'(alloc[0]), 0);
    // R8/R9: eliminated producer forwards its source.
    clear(); v[1:0] = 2'b11; rd[0] = 5; rs1[0] = 6; mp1[0] = 11;
    rd[1] = 7; rs1[1] = 5; mp1[1] = 33; rs2[1] = 8; mp2[1] = 20; settle();
    chk("R9 fwd elim name", int'(s1[1]), 11);
    chk("R8 map second src", int'(s2[1]), 20);
    // R9: zero status forwarded from zero move -> consumer moves second.
    clear(); v[1:0] = 2'b11; op[0] = 3; rd[0] = 5; rs1[0] = 2; mp1[0] = 9;
    rd[1] = 6; rs1[1] = 5; mp1[1] = 30; rs2[1] = 9; mp2[1] = 14; settle();
    chk("R9 zero status fwd", int'(kind[1]), 2);
    chk("R10 move second data", int'(wdata[1]), 14);
    // R8: scheduled producer forwards its new register.
    clear(); v[1:0] = 2'b11; op[0] = 4; rd[0] = 4; rs1[0] = 1; mp1[0] = 2;
    rd[1] = 6; op[1] = 4; rs2[1] = 4; mp2[1] = 50; settle();
    chk("R8 fwd alloc name", int'(s2[1]), 40);
    // R11: two writers of one register, only the younger writes.
    clear(); v = 4'b0101; op[0] = 4; op[2] = 4; rd[0] = 4; rd[2] = 4; settle();
    chk("R11 older suppressed", int'(we[0]), 0);
    chk("R11 younger writes", int'(we[2]), 1);
    chk("R7 both allocate", int'(alloc[0]) + int'(alloc[2]), 2);
    // R13: read addresses mirror sources.
    clear(); rs1[3] = 17; rs2[3] = 29; settle();
    chk("R13 addr1", int'(ra1[3]), 17);
    chk("R13 addr2", int'(ra2[3]), 29);

    // Constrained random windows.
    for (int t = 0; t < 400; t++) begin
      @(posedge clk); #1;
      for (int i = 0; i < N; i++) begin
        v[i] = ($urandom % 8) != 0;
        op[i] = ($urandom % 4 == 0) ? 3'($urandom % 8) : 3'($urandom % 4);
        rd[i]  = ($urandom % 8 == 0) ? AW'($urandom) : AW'($urandom % 8);
        rs1[i] = ($urandom % 8 == 0) ? AW'($urandom) : AW'($urandom % 8);
        rs2[i] = ($urandom % 8 == 0) ? AW'($urandom) : AW'($urandom % 8);
        use_imm[i] = ($urandom % 3) == 0;
        imm_z[i] = ($urandom % 3) == 0;
        az_d[i] = ($urandom % 10) == 0;
        bz_d[i] = ($urandom % 10) == 0;
        mp1[i] = ($urandom % 4 == 0) ? '0 : PW'($urandom % 16);
        mp2[i] = ($urandom % 4 == 0) ? '0 : PW'($urandom % 16);
        mz1[i] = (mp1[i] == '0);
        mz2[i] = (mp2[i] == '0);
        flp[i] = PW'(1 + ($urandom % 63));
      end
      model();
      @(negedge clk);
      chk_all("rand");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule